// File: doc/BRIEF.md
# Dual Byte FIFO with Threshold Status

This block holds the transmit and receive data of a serial controller in two byte-wide queues. The register side of the controller moves whole 32-bit words. It pushes a word into the transmit queue and pops a word from the receive queue. The serial shift engine moves single bytes: it takes them from the head of the transmit queue and appends them to the receive queue. A word is split into bytes, and bytes are joined into a word, least significant byte first.

Each queue reports five conditions: full, empty, a ready flag set by a programmable 3-bit threshold, a sticky overflow flag and a sticky underflow flag. The transmit ready flag compares free space with its threshold. The receive ready flag compares stored bytes with its threshold. With word size N bytes, software sets the transmit threshold to 7-N and the receive threshold to N-1. A flush request raises a busy flag. On the following cycle the flag drops by itself, and both queues are then empty with their sticky flags cleared.

Top module: `dual_byte_fifo`

## Requirements
- R1: After a synchronous active-low reset, both queues are empty and not full, both ready flags follow an empty queue, every overflow and underflow flag is 0, and flush_busy is 0.
- R2: A word pushed into the transmit queue leaves as four bytes, bits 7:0 first and bits 31:24 last, and tx_byte always shows the oldest stored byte.
- R3: Four bytes pushed into the receive queue appear on rd_word with the first byte in bits 7:0 and the fourth in bits 31:24.
- R4: tx_full is 1 while the transmit queue holds more than 4 of its 8 bytes, so no further word fits. tx_empty is 1 while it holds 0 bytes.
- R5: rx_full is 1 while the receive queue holds 8 bytes. rx_empty is 1 while it holds fewer than 4 bytes, so no whole word is available.
- R6: tx_ready is 1 exactly when the free transmit bytes (8 minus stored) are greater than tx_thr.
- R7: rx_ready is 1 exactly when the stored receive bytes are greater than rx_thr.
- R8: A push into a full queue is discarded, leaves the stored data intact and sets that queue's overflow flag. The flag stays set until reset or flush.
- R9: A pop from an empty queue changes nothing stored and sets that queue's underflow flag. The flag stays set until reset or flush.
- R10: A flush_set pulse makes flush_busy 1 for exactly one cycle. When it falls, both queues are empty and all four sticky flags are 0. Pushes and pops presented while flush_busy is 1 are ignored.
- R11: A push and a pop on the same queue in the same cycle both take effect, each judged on the state before that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush_set | input | 1 | Request to empty both queues |
| flush_busy | output | 1 | Flush in progress; clears itself |
| wr_word_valid | input | 1 | Push wr_word into the transmit queue |
| wr_word | input | 32 | Word to transmit |
| rd_word_pop | input | 1 | Pop one word from the receive queue |
| rd_word | output | 32 | Oldest four received bytes, little-endian |
| tx_thr | input | 3 | Transmit ready threshold (free bytes) |
| rx_thr | input | 3 | Receive ready threshold (stored bytes) |
| tx_byte_pop | input | 1 | Shift engine takes one transmit byte |
| tx_byte | output | 8 | Oldest transmit byte |
| rx_byte_push | input | 1 | Shift engine delivers one received byte |
| rx_byte | input | 8 | Received byte |
| tx_full | output | 1 | No room for another word |
| tx_empty | output | 1 | Transmit queue holds no byte |
| tx_ready | output | 1 | Free transmit bytes exceed tx_thr |
| tx_ovf | output | 1 | Sticky transmit overflow |
| tx_udf | output | 1 | Sticky transmit underflow |
| rx_full | output | 1 | Receive queue holds 8 bytes |
| rx_empty | output | 1 | Fewer than 4 received bytes stored |
| rx_ready | output | 1 | Stored receive bytes exceed rx_thr |
| rx_ovf | output | 1 | Sticky receive overflow |
| rx_udf | output | 1 | Sticky receive underflow |

## Verification
The packing path is tried with a set of words whose four bytes all differ, including words with only one lane set and alternating bit patterns. These show whether the byte order is reversed, whether a lane is dropped, and whether lanes alias. The pointers are also driven across the wrap of the 8-byte store: mixed push and pop in one cycle leaves the read and write positions offset. This tells correct modulo indexing apart from indexing that only works from position zero. The threshold flags are tested at the exact fill where the comparison changes, with values on both sides. The full, empty, overflow, underflow and flush cases are tested with data that must survive a rejected push.

// File: rtl/dfifo_pkg.sv
// Package: shared types of the dual byte FIFO.
// Assumes: nothing beyond IEEE 1800-2017.
package dfifo_pkg;

    // Status bundle that every byte queue reports.
    typedef struct packed {
        logic full;
        logic empty;
        logic ready;
        logic ovf;
        logic udf;
    } fifo_flags_t;

endpackage

// File: rtl/dfifo_flush_ctl.sv
// Module: self-clearing flush control.
// A request raises busy for exactly one cycle. That cycle is the clear
// strobe for the queues, after which busy returns to 0 without software.
// Assumes: flush_set is a single-cycle pulse from the register side.
module dfifo_flush_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic flush_set,
    output logic busy
);

    // Purpose: hold busy for one cycle after a request, then release it.
    always_ff @(posedge clk) begin
        if (!rst_n)      busy <= 1'b0;
        else if (busy)   busy <= 1'b0;
        else if (flush_set) busy <= 1'b1;
    end

    // R10: busy never lasts beyond one cycle.
    a_r10_busy_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy);

    // R10: a request while idle always raises busy.
    a_r10_busy_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_set && !busy) |=> busy);

endmodule

// File: rtl/dfifo_byte_store.sv
// Module: byte-wide circular queue with multi-byte push and pop units.
// The filling side writes IN_BYTES bytes per push and the draining side
// reads OUT_BYTES bytes per pop. Byte 0 of a unit is the oldest.
// full  : no room for another IN_BYTES unit.
// empty : fewer than OUT_BYTES bytes stored.
// ready : free bytes > thr (READY_ON_FREE=1) or stored bytes > thr (=0).
// Overflow and underflow flags are sticky until clear or reset.
// Assumes: DEPTH is a power of two, and IN_BYTES and OUT_BYTES are no
// larger than DEPTH.
module dfifo_byte_store
    import dfifo_pkg::*;
#(
    parameter int DEPTH         = 8,
    parameter int IN_BYTES      = 4,
    parameter int OUT_BYTES     = 1,
    parameter int THR_W         = 3,
    parameter bit READY_ON_FREE = 1'b1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clear,
    input  logic                   push,
    input  logic [IN_BYTES*8-1:0]  din,
    input  logic                   pop,
    output logic [OUT_BYTES*8-1:0] dout,
    input  logic [THR_W-1:0]       thr,
    output fifo_flags_t            flags
);

    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] FULL_LIM = CNT_W'(DEPTH - IN_BYTES);
    localparam logic [CNT_W-1:0] POP_MIN  = CNT_W'(OUT_BYTES);

    logic [7:0]       mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] free_bytes;
    logic             full_w;
    logic             empty_w;
    logic             push_ok;
    logic             pop_ok;
    logic             ready_w;
    logic             ovf_q;
    logic             udf_q;

    // Purpose: occupancy conditions seen by both sides.
    always_comb begin
        free_bytes = CNT_W'(DEPTH) - count;
        full_w     = count > FULL_LIM;
        empty_w    = count < POP_MIN;
        push_ok    = push && !full_w;
        pop_ok     = pop && !empty_w;
    end

    // Threshold compares free space or stored bytes, as the parameter picks.
    generate
        if (READY_ON_FREE) begin : g_ready_free
            assign ready_w = free_bytes > CNT_W'(thr);
        end else begin : g_ready_fill
            assign ready_w = count > CNT_W'(thr);
        end
    endgenerate

    // Head unit of the draining side, oldest byte in the low lane.
    generate
        for (genvar j = 0; j < OUT_BYTES; j++) begin : g_out_lane
            assign dout[8*j +: 8] = mem[rd_ptr + PTR_W'(j)];
        end
    endgenerate

    // Purpose: store the bytes of an accepted push unit.
    always_ff @(posedge clk) begin
        if (push_ok && !clear) begin
            for (int i = 0; i < IN_BYTES; i++) begin
                mem[wr_ptr + PTR_W'(i)] <= din[8*i +: 8];
            end
        end
    end

    // Purpose: move pointers and occupancy; flush wins over traffic.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= wr_ptr + PTR_W'(IN_BYTES);
            if (pop_ok)  rd_ptr <= rd_ptr + PTR_W'(OUT_BYTES);
            count <= count + (push_ok ? CNT_W'(IN_BYTES) : '0)
                           - (pop_ok  ? CNT_W'(OUT_BYTES) : '0);
        end
    end

    // Purpose: sticky error flags, set by a rejected access.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            ovf_q <= 1'b0;
            udf_q <= 1'b0;
        end else begin
            if (push && full_w) ovf_q <= 1'b1;
            if (pop && empty_w) udf_q <= 1'b1;
        end
    end

    assign flags = '{full: full_w, empty: empty_w, ready: ready_w,
                     ovf: ovf_q, udf: udf_q};

    // R4 / R5: occupancy never exceeds the store.
    a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));

    // R8: overflow stays set until a flush.
    a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && !clear) |=> ovf_q);

    // R8: a rejected push with no pop leaves the queue still full.
    a_r8_push_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full_w && !pop && !clear) |=> (full_w && $stable(wr_ptr)));

    // R9: underflow stays set until a flush.
    a_r9_udf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (udf_q && !clear) |=> udf_q);

    // R9: a pop from an empty queue does not move the read side.
    a_r9_pop_empty_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty_w && !clear) |=> $stable(rd_ptr));

    // R10: a clear strobe leaves the queue empty with no sticky flags.
    a_r10_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (count == '0 && !ovf_q && !udf_q));

endmodule

// File: rtl/dual_byte_fifo.sv
// Module: transmit and receive byte queues between a word-wide register
// side and a byte-wide shift engine, with threshold ready flags, sticky
// error flags and a self-clearing flush.
// Assumes: the register side raises wr_word_valid / rd_word_pop for one
// cycle per word; the shift engine raises tx_byte_pop / rx_byte_push for
// one cycle per byte.
module dual_byte_fifo
    import dfifo_pkg::*;
#(
    parameter int DEPTH      = 8,
    parameter int WORD_BYTES = 4,
    parameter int THR_W      = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    flush_set,
    output logic                    flush_busy,
    input  logic                    wr_word_valid,
    input  logic [WORD_BYTES*8-1:0] wr_word,
    input  logic                    rd_word_pop,
    output logic [WORD_BYTES*8-1:0] rd_word,
    input  logic [THR_W-1:0]        tx_thr,
    input  logic [THR_W-1:0]        rx_thr,
    input  logic                    tx_byte_pop,
    output logic [7:0]              tx_byte,
    input  logic                    rx_byte_push,
    input  logic [7:0]              rx_byte,
    output logic                    tx_full,
    output logic                    tx_empty,
    output logic                    tx_ready,
    output logic                    tx_ovf,
    output logic                    tx_udf,
    output logic                    rx_full,
    output logic                    rx_empty,
    output logic                    rx_ready,
    output logic                    rx_ovf,
    output logic                    rx_udf
);

    fifo_flags_t tx_flags;
    fifo_flags_t rx_flags;
    logic        busy;
    logic        tx_push_g;
    logic        tx_pop_g;
    logic        rx_push_g;
    logic        rx_pop_g;

    // Purpose: ignore all queue traffic during the flush cycle.
    always_comb begin
        tx_push_g = wr_word_valid && !busy;
        tx_pop_g  = tx_byte_pop   && !busy;
        rx_push_g = rx_byte_push  && !busy;
        rx_pop_g  = rd_word_pop   && !busy;
    end

    dfifo_flush_ctl u_flush (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush_set (flush_set),
        .busy      (busy)
    );

    dfifo_byte_store #(
        .DEPTH         (DEPTH),
        .IN_BYTES      (WORD_BYTES),
        .OUT_BYTES     (1),
        .THR_W         (THR_W),
        .READY_ON_FREE (1'b1)
    ) u_tx (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (busy),
        .push  (tx_push_g),
        .din   (wr_word),
        .pop   (tx_pop_g),
        .dout  (tx_byte),
        .thr   (tx_thr),
        .flags (tx_flags)
    );

    dfifo_byte_store #(
        .DEPTH         (DEPTH),
        .IN_BYTES      (1),
        .OUT_BYTES     (WORD_BYTES),
        .THR_W         (THR_W),
        .READY_ON_FREE (1'b0)
    ) u_rx (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (busy),
        .push  (rx_push_g),
        .din   (rx_byte),
        .pop   (rx_pop_g),
        .dout  (rd_word),
        .thr   (rx_thr),
        .flags (rx_flags)
    );

    assign flush_busy = busy;
    assign tx_full    = tx_flags.full;
    assign tx_empty   = tx_flags.empty;
    assign tx_ready   = tx_flags.ready;
    assign tx_ovf     = tx_flags.ovf;
    assign tx_udf     = tx_flags.udf;
    assign rx_full    = rx_flags.full;
    assign rx_empty   = rx_flags.empty;
    assign rx_ready   = rx_flags.ready;
    assign rx_ovf     = rx_flags.ovf;
    assign rx_udf     = rx_flags.udf;

    // R4: the transmit queue cannot be full and empty together.
    a_r4_tx_full_empty: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_full && tx_empty));

    // R5: the receive queue cannot be full and empty together.
    a_r5_rx_full_empty: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_full && rx_empty));

endmodule

// File: tb/tb_dual_byte_fifo.sv
`timescale 1ns/1ps
module tb_dual_byte_fifo;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush_set = 1'b0;
    logic        flush_busy;
    logic        wr_word_valid = 1'b0;
    logic [31:0] wr_word = '0;
    logic        rd_word_pop = 1'b0;
    logic [31:0] rd_word;
    logic [2:0]  tx_thr = 3'd3;
    logic [2:0]  rx_thr = 3'd3;
    logic        tx_byte_pop = 1'b0;
    logic [7:0]  tx_byte;
    logic        rx_byte_push = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        tx_full, tx_empty, tx_ready, tx_ovf, tx_udf;
    logic        rx_full, rx_empty, rx_ready, rx_ovf, rx_udf;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    dual_byte_fifo dut (
        .clk(clk), .rst_n(rst_n), .flush_set(flush_set), .flush_busy(flush_busy),
        .wr_word_valid(wr_word_valid), .wr_word(wr_word),
        .rd_word_pop(rd_word_pop), .rd_word(rd_word),
        .tx_thr(tx_thr), .rx_thr(rx_thr),
        .tx_byte_pop(tx_byte_pop), .tx_byte(tx_byte),
        .rx_byte_push(rx_byte_push), .rx_byte(rx_byte),
        .tx_full(tx_full), .tx_empty(tx_empty), .tx_ready(tx_ready),
        .tx_ovf(tx_ovf), .tx_udf(tx_udf),
        .rx_full(rx_full), .rx_empty(rx_empty), .rx_ready(rx_ready),
        .rx_ovf(rx_ovf), .rx_udf(rx_udf)
    );

    // Words with distinct bytes per lane, single-lane words and alternating bits.
    localparam logic [31:0] VEC [6] = '{
        32'h0403_0201, 32'hA1B2_C3D4, 32'h0000_00FF,
        32'hFF00_0000, 32'h55AA_33CC, 32'h8001_7FFE
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // All tasks start and end at a falling edge.
    task automatic tx_push(input logic [31:0] w);
        wr_word_valid = 1'b1; wr_word = w;
        @(negedge clk);
        wr_word_valid = 1'b0;
    endtask

    task automatic tx_take(input string req, input logic [7:0] exp);
        chk(req, {24'h0, tx_byte}, {24'h0, exp});
        tx_byte_pop = 1'b1;
        @(negedge clk);
        tx_byte_pop = 1'b0;
    endtask

    task automatic rx_give(input logic [7:0] b);
        rx_byte_push = 1'b1; rx_byte = b;
        @(negedge clk);
        rx_byte_push = 1'b0;
    endtask

    task automatic rx_take(input string req, input logic [31:0] exp);
        chk(req, rd_word, exp);
        rd_word_pop = 1'b1;
        @(negedge clk);
        rd_word_pop = 1'b0;
    endtask

    initial begin
        #200000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state.
        chk("R1 tx flags", {27'h0, tx_full, tx_empty, tx_ready, tx_ovf, tx_udf}, 32'b01100);
        chk("R1 rx flags", {27'h0, rx_full, rx_empty, rx_ready, rx_ovf, rx_udf}, 32'b01000);
        chk("R1 flush_busy", {31'h0, flush_busy}, 32'h0);

        // R2 / R3: table walk, word to bytes and bytes to word.
        for (int i = 0; i < 6; i++) begin
            tx_push(VEC[i]);
            for (int b = 0; b < 4; b++) tx_take("R2 byte order", VEC[i][8*b +: 8]);
            chk("R4 tx empty after drain", {31'h0, tx_empty}, 32'h1);
            for (int b = 0; b < 4; b++) rx_give(VEC[i][8*b +: 8]);
            rx_take("R3 word assembly", VEC[i]);
            chk("R5 rx empty after pop", {31'h0, rx_empty}, 32'h1);
        end

        // R6: transmit threshold on free space.
        tx_thr = 3'd7; #1;
        chk("R6 free 8 thr 7", {31'h0, tx_ready}, 32'h1);
        @(negedge clk);
        tx_push(32'h1122_3344);
        tx_thr = 3'd3; #1;
        chk("R6 free 4 thr 3", {31'h0, tx_ready}, 32'h1);
        tx_thr = 3'd4; #1;
        chk("R6 free 4 thr 4", {31'h0, tx_ready}, 32'h0);
        chk("R4 4 bytes not full", {31'h0, tx_full}, 32'h0);
        @(negedge clk);

        // R11: push a word and pop a byte in one cycle (count 4 -> 7).
        wr_word_valid = 1'b1; wr_word = 32'hCAFE_F00D;
        chk("R11 head before", {24'h0, tx_byte}, 32'h44);
        tx_byte_pop = 1'b1;
        @(negedge clk);
        wr_word_valid = 1'b0; tx_byte_pop = 1'b0;
        chk("R11 tx full at 7", {31'h0, tx_full}, 32'h1);
        tx_take("R11 seq", 8'h33); tx_take("R11 seq", 8'h22); tx_take("R11 seq", 8'h11);
        tx_take("R11 seq", 8'h0D); tx_take("R11 seq", 8'hF0);
        tx_take("R11 seq", 8'hFE); tx_take("R11 seq", 8'hCA);
        chk("R4 tx empty", {31'h0, tx_empty}, 32'h1);

        // R7 / R5: receive threshold and partial word.
        rx_give(8'h10); rx_give(8'h20); rx_give(8'h30);
        rx_thr = 3'd2; #1;
        chk("R7 stored 3 thr 2", {31'h0, rx_ready}, 32'h1);
        rx_thr = 3'd3; #1;
        chk("R7 stored 3 thr 3", {31'h0, rx_ready}, 32'h0);
        chk("R5 3 bytes empty", {31'h0, rx_empty}, 32'h1);
        @(negedge clk);
        rx_give(8'h40);
        chk("R5 4 bytes not empty", {31'h0, rx_empty}, 32'h0);

        // R11: receive push and word pop together (count 4 -> 1).
        rx_byte_push = 1'b1; rx_byte = 8'h50; rd_word_pop = 1'b1;
        chk("R11 rx word", rd_word, 32'h4030_2010);
        @(negedge clk);
        rx_byte_push = 1'b0; rd_word_pop = 1'b0;
        chk("R11 rx empty at 1", {31'h0, rx_empty}, 32'h1);
        rx_give(8'h60); rx_give(8'h70); rx_give(8'h80);
        rx_take("R11 rx wrapped word", 32'h8070_6050);

        // R8 / R9: transmit full, overflow, underflow.
        tx_push(32'h0D0C_0B0A); tx_push(32'h1D1C_1B1A);
        chk("R4 tx full at 8", {31'h0, tx_full}, 32'h1);
        tx_push(32'hDEAD_BEEF);
        chk("R8 tx ovf", {31'h0, tx_ovf}, 32'h1);
        for (int b = 0; b < 4; b++) tx_take("R8 data kept", 8'h0A + 8'(b));
        for (int b = 0; b < 4; b++) tx_take("R8 data kept", 8'h1A + 8'(b));
        chk("R4 tx empty after ovf", {31'h0, tx_empty}, 32'h1);
        chk("R8 tx ovf sticky", {31'h0, tx_ovf}, 32'h1);
        tx_byte_pop = 1'b1;
        @(negedge clk);
        tx_byte_pop = 1'b0;
        chk("R9 tx udf", {31'h0, tx_udf}, 32'h1);
        chk("R9 tx still empty", {31'h0, tx_empty}, 32'h1);

        // R8 / R9: receive full, overflow, underflow.
        for (int b = 0; b < 8; b++) rx_give(8'hA0 + 8'(b));
        chk("R5 rx full at 8", {31'h0, rx_full}, 32'h1);
        rx_give(8'hEE);
        chk("R8 rx ovf", {31'h0, rx_ovf}, 32'h1);
        rx_take("R8 rx data kept", 32'hA3A2_A1A0);
        rx_take("R8 rx data kept", 32'hA7A6_A5A4);
        rd_word_pop = 1'b1;
        @(negedge clk);
        rd_word_pop = 1'b0;
        chk("R9 rx udf", {31'h0, rx_udf}, 32'h1);
        chk("R8 rx ovf sticky", {31'h0, rx_ovf}, 32'h1);

        // R10: flush with data and flags present; traffic during busy ignored.
        tx_push(32'h0102_0304);
        rx_give(8'h99);
        flush_set = 1'b1;
        @(negedge clk);
        flush_set = 1'b0;
        chk("R10 busy set", {31'h0, flush_busy}, 32'h1);
        wr_word_valid = 1'b1; wr_word = 32'h7777_7777; rx_byte_push = 1'b1;
        @(negedge clk);
        wr_word_valid = 1'b0; rx_byte_push = 1'b0;
        chk("R10 busy self-clears", {31'h0, flush_busy}, 32'h0);
        chk("R10 tx flags", {27'h0, tx_full, tx_empty, tx_ready, tx_ovf, tx_udf}, 32'b01100);
        chk("R10 rx flags", {27'h0, rx_full, rx_empty, rx_ready, rx_ovf, rx_udf}, 32'b01000);
        rx_thr = 3'd0; #1;
        chk("R10 rx push during busy ignored", {31'h0, rx_ready}, 32'h0);
        @(negedge clk);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule